// File: doc/BRIEF.md
# Floating-Point Instruction Word Decoder with Register Bank Swapping

This block turns one 16-bit floating-point instruction word into a registered operation code, physical register-file indices and control flags. It takes the live floating-point status/control word along with the instruction. Three of its bits steer the decode: the bank select bit swaps the two halves of the 32-entry register file, the transfer-size bit turns moves into register-pair moves, and the precision bit is passed on to the datapath.

The function nibble is looked up in two levels. One function code opens a second table, indexed by the m field, of single-operand operations. One entry of that second table opens a third level, indexed by the n field, that requests a toggle of a status bit. Words outside the floating-point group are sent to a system-transfer path. That path reports whether the transfer targets the FPU communication register or the status register.

Each word presented with `in_valid` gives one result on the following clock edge. The result appears on `out_valid`, and the pipeline stage after this block consumes it.

Top module: `fpu_insn_decode`

## Requirements
- R1: A word whose bits 15:12 equal 0xF is a floating-point word. Any other word takes the system path: `sys_xfer_ul` = bit 4 of the word (1 selects the communication register, 0 the status register) and `sys_gpr` = bits 11:8. Its op is SYS (32) when bits 15:12 are 0x0 or 0x4. Otherwise `illegal` is 1 and op is NOP (15). On the system path all float index outputs are 0.
- R2: In a floating-point word, n = bits 11:8, m = bits 7:4 and f = bits 3:0. For f other than 13 the op output equals f. The values are ADD 0, SUB 1, MUL 2, DIV 3, CMP_EQ 4, CMP_GT 5, LD_IDX 6, ST_IDX 7, LD 8, LD_INC 9, ST 10, ST_DEC 11, MOVE 12, MAC 14, NOP 15.
- R3: For f = 13 the op is 16 + m for m in 0..11 and m = 14: TO_UL, FROM_UL, FLOAT, TRUNC, NEG, ABS, SQRT, RSQRT, LD_ZERO, LD_ONE, CVT_SD, CVT_DS, then IPR (30). For m = 12 or m = 13 the op is NOP (15).
- R4: For f = 13 and m = 15, the word needs n[1:0] = 3, otherwise it is illegal with op NOP. When n[1:0] = 3, n[3:2] picks the toggle: 0 gives `toggle_req` = 3'b001 (size bit), 1 gives 3'b010 (precision bit) and 2 gives 3'b100 (bank bit), each with op TOGGLE (31). 3 gives op NOP with no toggle.
- R5: Outside the pair-move case, the single index of a register field r is {status bit 21, r}. That is r XOR 16 when the bank bit is set.
- R6: A double index is its single index shifted right by one.
- R7: An extended index is {NOT status bit 21, r}, i.e. r XOR 16 before the bank swap.
- R8: For f in 6..12 with status bit 20 set, an odd r is first raised by 15. The bank XOR is applied after that. So an odd r maps to {NOT bit 21, r[3:1], 0} and an even r to {bit 21, r}.
- R9: `dbl_prec` equals status bit 19 of the accepted word. Status bits 31:22 have no effect on any output.
- R10: The outputs of a word accepted on a clock edge appear at that edge's registers, and `out_valid` is high for exactly that cycle. In a cycle after `in_valid` was low, `out_valid`, `toggle_req` and `illegal` are 0 and the other outputs hold their values.
- R11: After reset, `out_valid`, `illegal` and `toggle_req` are 0, op is NOP (15), and every index, `dbl_prec`, `sys_xfer_ul` and `sys_gpr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 16 | Instruction word |
| fpscr | input | 32 | Live floating-point status/control word |
| out_valid | output | 1 | Decoded result present |
| op_code | output | 6 | Decoded operation |
| dst_s | output | 5 | Physical single index of the n field |
| src_s | output | 5 | Physical single index of the m field |
| dst_d | output | 4 | Double index of the n field |
| src_d | output | 4 | Double index of the m field |
| dst_x | output | 5 | Extended-bank index of the n field |
| src_x | output | 5 | Extended-bank index of the m field |
| dbl_prec | output | 1 | Precision select |
| toggle_req | output | 3 | One-hot status toggle request {bank, precision, size} |
| illegal | output | 1 | Word not decodable |
| sys_xfer_ul | output | 1 | System path targets the communication register |
| sys_gpr | output | 4 | General register field of a system-path word |

## Verification
The bank swap and the pair-move remap can act on the same register field in the same cycle. This happens when a move function code arrives with both the size and bank bits set and an odd register number. The bench drives that combination directly on both fields, in both bank states, and also reaches it through random status words. For each case it compares the single, double and extended indices against a model that adds 15 and applies XOR 16 as integer arithmetic. The model does not concatenate bits, so any mistake in the order of the two steps shows up as a different index.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    localparam int INSN_W  = 16;
    localparam int SCR_W   = 32;
    localparam int FIELD_W = 4;
    localparam int IDX_W   = FIELD_W + 1;
    localparam int DIDX_W  = IDX_W - 1;
    localparam int OP_W    = 6;
    localparam int TOG_W   = 3;

    localparam int BIT_PREC = 19;
    localparam int BIT_SIZE = 20;
    localparam int BIT_BANK = 21;
    localparam logic [SCR_W-1:0] SCR_MASK = 32'h003F_FFFF;

    localparam logic [FIELD_W-1:0] GRP_FLOAT  = 4'hF;
    localparam logic [FIELD_W-1:0] GRP_SYS_A  = 4'h0;
    localparam logic [FIELD_W-1:0] GRP_SYS_B  = 4'h4;
    localparam logic [FIELD_W-1:0] F_UNARY    = 4'd13;
    localparam logic [FIELD_W-1:0] M_EXT      = 4'd15;
    localparam logic [OP_W-1:0]    UNARY_BASE = 6'd16;

    typedef enum logic [OP_W-1:0] {
        OP_ADD     = 6'd0,
        OP_SUB     = 6'd1,
        OP_MUL     = 6'd2,
        OP_DIV     = 6'd3,
        OP_CMP_EQ  = 6'd4,
        OP_CMP_GT  = 6'd5,
        OP_LD_IDX  = 6'd6,
        OP_ST_IDX  = 6'd7,
        OP_LD      = 6'd8,
        OP_LD_INC  = 6'd9,
        OP_ST      = 6'd10,
        OP_ST_DEC  = 6'd11,
        OP_MOVE    = 6'd12,
        OP_MAC     = 6'd14,
        OP_NOP     = 6'd15,
        OP_TO_UL   = 6'd16,
        OP_FROM_UL = 6'd17,
        OP_FLOAT   = 6'd18,
        OP_TRUNC   = 6'd19,
        OP_NEG     = 6'd20,
        OP_ABS     = 6'd21,
        OP_SQRT    = 6'd22,
        OP_RSQRT   = 6'd23,
        OP_LD_ZERO = 6'd24,
        OP_LD_ONE  = 6'd25,
        OP_CVT_SD  = 6'd26,
        OP_CVT_DS  = 6'd27,
        OP_IPR     = 6'd30,
        OP_TOGGLE  = 6'd31,
        OP_SYS     = 6'd32
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             illegal;
        logic [TOG_W-1:0] toggle;
        logic             is_move;
        logic             is_sys;
    } dec_t;

    function automatic logic is_move_code(input logic [FIELD_W-1:0] f);
        return (f >= 4'd6) && (f <= 4'd12);
    endfunction

    function automatic logic [TOG_W-1:0] toggle_onehot(input logic [1:0] sel);
        logic [TOG_W-1:0] t;
        t = '0;
        if (sel != 2'd3) t[sel] = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/fpdec_opmap.sv
module fpdec_opmap
    import fpdec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [FIELD_W-1:0] grp, fn, fm, ff;

    assign grp = insn[15:12];
    assign fn  = insn[11:8];
    assign fm  = insn[7:4];
    assign ff  = insn[3:0];

    always_comb begin
        dec         = '0;
        dec.op      = OP_NOP;
        if (grp != GRP_FLOAT) begin
            dec.is_sys = 1'b1;
            if (grp == GRP_SYS_A || grp == GRP_SYS_B) dec.op = OP_SYS;
            else                                     dec.illegal = 1'b1;
        end else if (ff != F_UNARY) begin
            dec.op      = op_e'({2'b00, ff});
            dec.is_move = is_move_code(ff);
        end else if (fm == M_EXT) begin
            if (fn[1:0] != 2'b11) begin
                dec.illegal = 1'b1;
            end else begin
                dec.toggle = toggle_onehot(fn[3:2]);
                if (fn[3:2] != 2'd3) dec.op = OP_TOGGLE;
            end
        end else if (fm == 4'd12 || fm == 4'd13) begin
            dec.op = OP_NOP;
        end else begin
            dec.op = op_e'(UNARY_BASE + {2'b00, fm});
        end
    end
endmodule

// File: rtl/fpdec_bankmap.sv
module fpdec_bankmap
    import fpdec_pkg::*;
#(
    parameter int RW = FIELD_W,
    localparam int IW = RW + 1
)(
    input  logic [RW-1:0] reg_num,
    input  logic          bank,
    input  logic          pair,
    output logic [IW-1:0] s_idx,
    output logic [IW-2:0] d_idx,
    output logic [IW-1:0] x_idx
);
    logic [IW-1:0] logical;
    logic [IW-1:0] swap;

    assign swap = {bank, {RW{1'b0}}};

    always_comb begin
        if (pair) logical = {reg_num[0], reg_num[RW-1:1], 1'b0};
        else      logical = {1'b0, reg_num};
    end

    assign s_idx = logical ^ swap;
    assign d_idx = s_idx[IW-1:1];
    assign x_idx = {1'b1, reg_num} ^ swap;
endmodule

// File: rtl/fpu_insn_decode.sv
module fpu_insn_decode
    import fpdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [SCR_W-1:0]  fpscr,
    output logic              out_valid,
    output logic [OP_W-1:0]   op_code,
    output logic [IDX_W-1:0]  dst_s,
    output logic [IDX_W-1:0]  src_s,
    output logic [DIDX_W-1:0] dst_d,
    output logic [DIDX_W-1:0] src_d,
    output logic [IDX_W-1:0]  dst_x,
    output logic [IDX_W-1:0]  src_x,
    output logic              dbl_prec,
    output logic [TOG_W-1:0]  toggle_req,
    output logic              illegal,
    output logic              sys_xfer_ul,
    output logic [FIELD_W-1:0] sys_gpr
);
    localparam int NFIELD = 2;

    logic [SCR_W-1:0] scr;
    dec_t             dec;
    logic             pair;

    logic [FIELD_W-1:0] fld [NFIELD];
    logic [IDX_W-1:0]   s_c [NFIELD];
    logic [DIDX_W-1:0]  d_c [NFIELD];
    logic [IDX_W-1:0]   x_c [NFIELD];

    assign scr    = fpscr & SCR_MASK;
    assign fld[0] = insn[11:8];
    assign fld[1] = insn[7:4];
    assign pair   = dec.is_move & scr[BIT_SIZE];

    fpdec_opmap u_opmap (
        .insn (insn),
        .dec  (dec)
    );

    for (genvar g = 0; g < NFIELD; g++) begin : g_map
        fpdec_bankmap #(.RW(FIELD_W)) u_map (
            .reg_num (fld[g]),
            .bank    (scr[BIT_BANK]),
            .pair    (pair),
            .s_idx   (s_c[g]),
            .d_idx   (d_c[g]),
            .x_idx   (x_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            op_code     <= OP_NOP;
            dst_s       <= '0;
            src_s       <= '0;
            dst_d       <= '0;
            src_d       <= '0;
            dst_x       <= '0;
            src_x       <= '0;
            dbl_prec    <= 1'b0;
            toggle_req  <= '0;
            illegal     <= 1'b0;
            sys_xfer_ul <= 1'b0;
            sys_gpr     <= '0;
        end else begin
            out_valid  <= in_valid;
            toggle_req <= in_valid ? dec.toggle : '0;
            illegal    <= in_valid & dec.illegal;
            if (in_valid) begin
                op_code  <= dec.op;
                dbl_prec <= scr[BIT_PREC];
                if (dec.is_sys) begin
                    dst_s       <= '0;
                    src_s       <= '0;
                    dst_d       <= '0;
                    src_d       <= '0;
                    dst_x       <= '0;
                    src_x       <= '0;
                    sys_xfer_ul <= insn[4];
                    sys_gpr     <= insn[11:8];
                end else begin
                    dst_s       <= s_c[0];
                    src_s       <= s_c[1];
                    dst_d       <= d_c[0];
                    src_d       <= d_c[1];
                    dst_x       <= x_c[0];
                    src_x       <= x_c[1];
                    sys_xfer_ul <= 1'b0;
                    sys_gpr     <= '0;
                end
            end
        end
    end

    // R10: result strobe follows the accepted word by one edge
    a_r10_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && toggle_req == '0 && !illegal));
    // R4: at most one status toggle, only with the toggle op
    a_r4_toggle_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(toggle_req));
    a_r4_toggle_op: assert property (@(posedge clk) disable iff (rst)
        (toggle_req != '0) |-> (op_code == OP_TOGGLE));
    // R1: undecodable words report a no-op
    a_r1_illegal_nop: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (op_code == OP_NOP));
    // R5: bank bit lands on the top index bit outside pair moves
    a_r5_bank_swap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[15:12] == GRP_FLOAT && !(is_move_code(insn[3:0]) && fpscr[BIT_SIZE]))
        |=> (dst_s == {$past(fpscr[BIT_BANK]), $past(insn[11:8])}));
    // R6: double index tracks the single index
    a_r6_double_idx: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dst_d == dst_s[IDX_W-1:1] && src_d == src_s[IDX_W-1:1]));
    // R9: precision flag is the precision bit of the accepted word
    a_r9_prec: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dbl_prec == $past(fpscr[BIT_PREC])));
endmodule

// File: tb/fpu_insn_decode_tb.sv
module fpu_insn_decode_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] fpscr = '0;
    logic        out_valid;
    logic [5:0]  op_code;
    logic [4:0]  dst_s, src_s, dst_x, src_x;
    logic [3:0]  dst_d, src_d;
    logic        dbl_prec;
    logic [2:0]  toggle_req;
    logic        illegal;
    logic        sys_xfer_ul;
    logic [3:0]  sys_gpr;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fpu_insn_decode u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .fpscr(fpscr),
        .out_valid(out_valid), .op_code(op_code),
        .dst_s(dst_s), .src_s(src_s), .dst_d(dst_d), .src_d(src_d),
        .dst_x(dst_x), .src_x(src_x), .dbl_prec(dbl_prec),
        .toggle_req(toggle_req), .illegal(illegal),
        .sys_xfer_ul(sys_xfer_ul), .sys_gpr(sys_gpr)
    );

    typedef struct {
        int op; int ill; int tog;
        int ns; int ms; int nd; int md; int nx; int mx;
        int prec; int sf; int sg; int pairmv;
    } exp_t;

    exp_t last;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int map_s(input int r, input int bank, input int pairmv);
        int v;
        v = r;
        if (pairmv != 0 && (r % 2) == 1) v = r + 15;
        if (bank != 0) v = v ^ 16;
        return v;
    endfunction

    function automatic exp_t model(input logic [15:0] w, input logic [31:0] s);
        exp_t e;
        int top, n, m, f, bank;
        top = int'(w[15:12]); n = int'(w[11:8]); m = int'(w[7:4]); f = int'(w[3:0]);
        bank = int'(s[21]);
        e = '{op:15, ill:0, tog:0, ns:0, ms:0, nd:0, md:0, nx:0, mx:0,
              prec:int'(s[19]), sf:0, sg:0, pairmv:0};
        if (top != 15) begin
            e.sf = int'(w[4]); e.sg = n;
            if (top == 0 || top == 4) e.op = 32; else e.ill = 1;
            return e;
        end
        if (f != 13) e.op = f;
        else if (m == 15) begin
            if (n % 4 != 3) e.ill = 1;
            else if (n / 4 == 0) begin e.op = 31; e.tog = 1; end
            else if (n / 4 == 1) begin e.op = 31; e.tog = 2; end
            else if (n / 4 == 2) begin e.op = 31; e.tog = 4; end
        end else if (m == 12 || m == 13) e.op = 15;
        else e.op = 16 + m;
        e.pairmv = (f >= 6 && f <= 12 && s[20]) ? 1 : 0;
        e.ns = map_s(n, bank, e.pairmv);
        e.ms = map_s(m, bank, e.pairmv);
        e.nd = e.ns / 2;
        e.md = e.ms / 2;
        e.nx = (n + 16) ^ (bank != 0 ? 16 : 0);
        e.mx = (m + 16) ^ (bank != 0 ? 16 : 0);
        return e;
    endfunction

    task automatic check_all(input exp_t e, input logic [15:0] w);
        string otag, itag;
        otag = (w[15:12] != 4'hF) ? "R1 op" : (w[3:0] == 4'd13 ? "R3 op" : "R2 op");
        itag = (e.pairmv != 0) ? "R8 idx" : "R5 idx";
        chk("R10 out_valid", int'(out_valid), 1);
        chk(otag, int'(op_code), e.op);
        chk((w[15:12] != 4'hF) ? "R1 illegal" : "R4 illegal", int'(illegal), e.ill);
        chk("R4 toggle", int'(toggle_req), e.tog);
        chk({itag, " dst"}, int'(dst_s), e.ns);
        chk({itag, " src"}, int'(src_s), e.ms);
        chk("R6 dst_d", int'(dst_d), e.nd);
        chk("R6 src_d", int'(src_d), e.md);
        chk("R7 dst_x", int'(dst_x), (w[15:12] != 4'hF) ? 0 : e.nx);
        chk("R7 src_x", int'(src_x), (w[15:12] != 4'hF) ? 0 : e.mx);
        chk("R9 prec", int'(dbl_prec), e.prec);
        chk("R1 sys_ul", int'(sys_xfer_ul), e.sf);
        chk("R1 sys_gpr", int'(sys_gpr), e.sg);
    endtask

    task automatic apply(input logic [15:0] w, input logic [31:0] s);
        exp_t e;
        e = model(w, s);
        if (w[15:12] != 4'hF) begin e.nx = 0; e.mx = 0; end
        insn = w; fpscr = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_all(e, w);
        last = e;
    endtask

    task automatic idle(input logic [15:0] w, input logic [31:0] s);
        insn = w; fpscr = s; in_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle out_valid", int'(out_valid), 0);
        chk("R10 idle toggle", int'(toggle_req), 0);
        chk("R10 idle illegal", int'(illegal), 0);
        chk("R10 hold op", int'(op_code), last.op);
        chk("R10 hold dst", int'(dst_s), last.ns);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 op", int'(op_code), 15);
        chk("R11 illegal", int'(illegal), 0);
        chk("R11 toggle", int'(toggle_req), 0);
        chk("R11 dst", int'(dst_s), 0);
        chk("R11 src_x", int'(src_x), 0);
        chk("R11 prec", int'(dbl_prec), 0);
        chk("R11 gpr", int'(sys_gpr), 0);
        rst = 1'b0;
        @(negedge clk);

        // R8 with R5: pair move, odd fields, both bank states
        apply(16'hF35C, 32'h0010_0000);
        apply(16'hF35C, 32'h0030_0000);
        apply(16'hF246, 32'h0030_0000);
        apply(16'hF79B, 32'h0020_0000);
        // R4 toggles and extended-group corner cases
        apply(16'hF3FD, 32'h0);
        apply(16'hF7FD, 32'h0);
        apply(16'hFBFD, 32'h0);
        apply(16'hFFFD, 32'h0);
        apply(16'hF1FD, 32'h0);
        // R3 no-op slots and inner product
        apply(16'hF2CD, 32'h0);
        apply(16'hF2ED, 32'h0020_0000);
        // R1 system path
        apply(16'h4A5A, 32'h0);
        apply(16'h036A, 32'h0);
        apply(16'h2F5A, 32'h0);
        // R9 bits above 21 ignored
        apply(16'hF120, 32'hFFC0_0000);
        apply(16'hF120, 32'hFFE8_0000);
        idle(16'hFBFD, 32'hFFFF_FFFF);

        for (int i = 0; i < 1500; i++) begin
            logic [15:0] w;
            logic [31:0] s;
            w = 16'($urandom());
            if ($urandom_range(9) < 7) w[15:12] = 4'hF;
            if ($urandom_range(7) == 0) w[3:0] = 4'd13;
            s = $urandom();
            if ($urandom_range(15) == 0) idle(w, s);
            else apply(w, s);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule